// File: doc/BRIEF.md
# Multi-Mode UART Bit-Timing Generator

This block produces the bit timing for a serial port that can oversample each bit by different amounts. A free-running prescaler divides the system clock by a 16-bit divisor and emits a one-cycle tick. A mode field decides how many of those ticks form one bit: a fixed 16, a fixed 4, or a programmed count of 1 to 256. A separate sample-index field picks the tick inside each bit at which the receiver reads the line. This moves the sampling instant off the fixed mid-bit point of a plain 16x design.

A small byte-wide register port holds the divisor, line control, mode, tick count and sample index. It also reports line status. A minimal 8N1 transmitter and receiver run on the shared strobes. Software programs the divisor and timing fields, writes a byte to send, polls the status bits, and reads received bytes from the data address.

Top module: `mmuart_core`

## Requirements
- R1: The prescaler emits one tick every D clocks, where D is the 16-bit divisor. The divisor resets to 1. While line-control bit 7 is set, its low byte is read and written at address 0 and its high byte at address 1. While that bit is clear, address 1 reads 0 and ignores writes.
- R2: Mode register (address 2, bits [1:0]) sets the ticks per bit: value 2 gives 4, value 3 gives the tick-count register (address 4, reset 15) plus one, and values 0 and 1 give 16. Mode resets to 0.
- R3: A divisor of 0 behaves exactly like a divisor of 1, with a tick on every clock.
- R4: The receiver reads the line on the tick whose index within the bit equals the sample-index register (address 6, reset 7). An index at or beyond the ticks per bit is clamped to the last tick of the bit.
- R5: The transmit line idles high. A frame is a low start bit, 8 data bits with the least significant bit first, and a high stop bit. Each bit lasts ticks-per-bit ticks, so the frame spans between (10·T−1)·D+1 and 10·T·D clocks from the write.
- R6: Status at address 5: bit 0 = received byte ready, bit 5 = transmit holding empty, bit 6 = transmitter idle; all other bits read 0 and the value after reset is 0x60. A data write (address 0, line-control bit 7 clear) clears bits 5 and 6 until the stop bit ends. A data write made while they are clear is ignored.
- R7: A receive frame starts on a falling edge of the line. It is dropped, with no byte stored, if the line is high again at the start bit's sample tick.
- R8: Reading address 0 with line-control bit 7 clear returns the last received byte and clears the ready bit.
- R9: The line-control register (address 3) resets to 0 and reads back as written. Bit 7 selects divisor access, and bits [1:0] = 2'b11 name the 8-bit frame, which is the only one sent and received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effect on data address only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| rxd_i | input | 1 | Serial receive line, asynchronous |
| txd_o | output | 1 | Serial transmit line |

## Verification
Several properties are checked on every cycle by the assertions. A tick appears on every clock for a divisor of 0 or 1, and ticks never fall on back-to-back clocks for larger divisors. The transmit line only moves on a tick during a frame. Status bits 5 and 6 read clear while a frame is being sent, and a busy-time data write leaves the shift register alone. A start bit found high at its sample tick drops the frame, and a data read clears the ready bit. The bench scenarios are needed for the rest: the exact frame length for each mode and divisor, the bit order, and loopback reception across modes. They also show where the sample index lands inside a bit, which pulse widths count as a real start, and the clamping of an oversized sample index.

// File: rtl/mmuart_pkg.sv
package mmuart_pkg;
  localparam int DIV_W  = 16;
  localparam int DATA_W = 8;
  localparam int SC_W   = 8;
  localparam int TPB_W  = SC_W + 1;

  localparam logic [2:0] A_DATA   = 3'd0;
  localparam logic [2:0] A_DIVHI  = 3'd1;
  localparam logic [2:0] A_MODE   = 3'd2;
  localparam logic [2:0] A_LINE   = 3'd3;
  localparam logic [2:0] A_SCOUNT = 3'd4;
  localparam logic [2:0] A_STATUS = 3'd5;
  localparam logic [2:0] A_SPOINT = 3'd6;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/mmuart_prescale.sv
module mmuart_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;

  always_comb begin
    div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    tick_o  = (cnt_q >= div_eff - DIV_W'(1));
    cnt_d   = tick_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // R3: divisor 0 or 1 ticks on every clock
  p_div_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i <= DIV_W'(1)) |-> tick_o);
  // R1: larger divisor never ticks on consecutive clocks
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i > DIV_W'(1)) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/mmuart_tx.sv
module mmuart_tx #(
  parameter int DATA_W = 8,
  parameter int TPB_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TPB_W-1:0]  tpb_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int FR_W = DATA_W + 2;
  localparam int NB_W = $clog2(FR_W + 1);

  logic [FR_W-1:0]  sh_q, sh_d;
  logic [NB_W-1:0]  nbit_q, nbit_d;
  logic [TPB_W-1:0] tcnt_q, tcnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    nbit_d = nbit_q;
    tcnt_d = tcnt_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (load_i) begin
        sh_d   = {1'b1, data_i, 1'b0};
        nbit_d = '0;
        tcnt_d = '0;
        busy_d = 1'b1;
      end
    end else if (tick_i) begin
      if (tcnt_q >= tpb_i - TPB_W'(1)) begin
        tcnt_d = '0;
        if (nbit_q == NB_W'(FR_W - 1)) begin
          busy_d = 1'b0;
        end else begin
          nbit_d = nbit_q + NB_W'(1);
          sh_d   = {1'b1, sh_q[FR_W-1:1]};
        end
      end else begin
        tcnt_d = tcnt_q + TPB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q   <= '1;
      nbit_q <= '0;
      tcnt_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      nbit_q <= nbit_d;
      tcnt_q <= tcnt_d;
      busy_q <= busy_d;
    end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign busy_o = busy_q;

  // R5: a frame opens with a low start bit
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd_o);
  // R5: during a frame the line only moves on a tick
  p_line_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i) |=> $stable(txd_o));
  // R6: a write made while busy leaves the frame untouched
  p_busy_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && load_i && !tick_i) |=> $stable(sh_q));
endmodule

// File: rtl/mmuart_rx.sv
module mmuart_rx
  import mmuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SC_W   = 8,
  parameter int TPB_W  = SC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TPB_W-1:0]  tpb_i,
  input  logic [SC_W-1:0]   spt_i,
  input  logic              rxd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o
);
  localparam int NB_W = $clog2(DATA_W);

  rx_state_t         st_q, st_d;
  logic [2:0]        sync_q;
  logic [TPB_W-1:0]  tcnt_q, tcnt_d, sp_eff;
  logic [NB_W-1:0]   nbit_q, nbit_d;
  logic [DATA_W-1:0] sh_q, sh_d, data_q, data_d;
  logic              rdy_q, rdy_d;
  logic              line, fall, smp, last, done;

  always_comb begin
    line   = sync_q[1];
    fall   = sync_q[2] & ~sync_q[1];
    sp_eff = ({1'b0, spt_i} >= tpb_i) ? tpb_i - TPB_W'(1) : {1'b0, spt_i};
    smp    = tick_i && (tcnt_q == sp_eff);
    last   = tcnt_q >= tpb_i - TPB_W'(1);
    done   = 1'b0;
    st_d   = st_q;
    tcnt_d = tcnt_q;
    nbit_d = nbit_q;
    sh_d   = sh_q;
    data_d = data_q;
    if (st_q == RX_IDLE) begin
      if (fall) begin
        st_d   = RX_START;
        tcnt_d = '0;
        nbit_d = '0;
      end
    end else if (tick_i) begin
      tcnt_d = last ? '0 : tcnt_q + TPB_W'(1);
      if (smp && st_q == RX_DATA) sh_d = {line, sh_q[DATA_W-1:1]};
      case (st_q)
        RX_START:
          if (smp && line)  st_d = RX_IDLE;
          else if (last)    st_d = RX_DATA;
        RX_DATA:
          if (last) begin
            if (nbit_q == NB_W'(DATA_W - 1)) st_d = RX_STOP;
            else nbit_d = nbit_q + NB_W'(1);
          end
        RX_STOP:
          if (smp) begin
            st_d   = RX_IDLE;
            data_d = sh_q;
            done   = 1'b1;
          end
        default: st_d = RX_IDLE;
      endcase
    end
    rdy_d = done | (rdy_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sync_q <= '1;
      tcnt_q <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sync_q <= {sync_q[1:0], rxd_i};
      tcnt_q <= tcnt_d;
      nbit_q <= nbit_d;
      sh_q   <= sh_d;
      data_q <= data_d;
      rdy_q  <= rdy_d;
    end

  assign data_o  = data_q;
  assign ready_o = rdy_q;

  // R7: start bit found high at its sample tick drops the frame
  p_false_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && smp && line) |=> (st_q == RX_IDLE && $stable(data_q)));
  // R8: a data read clears ready unless a byte lands in the same cycle
  p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !done) |=> !ready_o);
endmodule

// File: rtl/mmuart_core.sv
module mmuart_core
  import mmuart_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       rxd_i,
  output logic       txd_o
);
  logic [7:0]       line_q, line_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [1:0]       mode_q, mode_d;
  logic [SC_W-1:0]  scnt_q, scnt_d, spt_q, spt_d;
  logic [TPB_W-1:0] tpb;
  logic             dlab, tx_load, rx_clr, tick, tx_busy, rx_rdy;
  logic [DATA_W-1:0] rx_byte;

  assign dlab = line_q[7];

  always_comb begin
    case (mode_q)
      2'd2:    tpb = TPB_W'(4);
      2'd3:    tpb = {1'b0, scnt_q} + TPB_W'(1);
      default: tpb = TPB_W'(16);
    endcase
  end

  always_comb begin
    line_d  = line_q;
    div_d   = div_q;
    mode_d  = mode_q;
    scnt_d  = scnt_q;
    spt_d   = spt_q;
    tx_load = 1'b0;
    if (wr_i) begin
      case (addr_i)
        A_DATA:   if (dlab) div_d[7:0] = wdata_i; else tx_load = 1'b1;
        A_DIVHI:  if (dlab) div_d[DIV_W-1:8] = wdata_i;
        A_MODE:   mode_d = wdata_i[1:0];
        A_LINE:   line_d = wdata_i;
        A_SCOUNT: scnt_d = wdata_i;
        A_SPOINT: spt_d  = wdata_i;
        default:  ;
      endcase
    end
    rx_clr = rd_i && (addr_i == A_DATA) && !dlab;
  end

  always_comb begin
    case (addr_i)
      A_DATA:   rdata_o = dlab ? div_q[7:0] : rx_byte;
      A_DIVHI:  rdata_o = dlab ? div_q[DIV_W-1:8] : 8'h00;
      A_MODE:   rdata_o = {6'b0, mode_q};
      A_LINE:   rdata_o = line_q;
      A_SCOUNT: rdata_o = scnt_q;
      A_STATUS: rdata_o = {1'b0, ~tx_busy, ~tx_busy, 4'b0, rx_rdy};
      A_SPOINT: rdata_o = spt_q;
      default:  rdata_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      line_q <= 8'h00;
      div_q  <= DIV_W'(1);
      mode_q <= 2'd0;
      scnt_q <= SC_W'(15);
      spt_q  <= SC_W'(7);
    end else begin
      line_q <= line_d;
      div_q  <= div_d;
      mode_q <= mode_d;
      scnt_q <= scnt_d;
      spt_q  <= spt_d;
    end

  mmuart_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick));

  mmuart_tx #(.DATA_W(DATA_W), .TPB_W(TPB_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .tpb_i(tpb), .load_i(tx_load),
    .data_i(wdata_i), .txd_o(txd_o), .busy_o(tx_busy));

  mmuart_rx #(.DATA_W(DATA_W), .SC_W(SC_W), .TPB_W(TPB_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .tpb_i(tpb), .spt_i(spt_q),
    .rxd_i(rxd_i), .clr_i(rx_clr), .data_o(rx_byte), .ready_o(rx_rdy));

  // R6: status shows both transmit bits clear for the whole frame
  p_status_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_STATUS && tx_busy) |-> (rdata_o[6:5] == 2'b00));
  // R1: divisor high byte is hidden while the access bit is clear
  p_divhi_hidden_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == A_DIVHI && !line_q[7]) |-> (rdata_o == 8'h00));
endmodule

// File: tb/mmuart_core_test.sv
module mmuart_core_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, wr, rd, rxd, txd, loop, rxd_drv;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  assign rxd = loop ? txd : rxd_drv;

  mmuart_core uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rxd_i(rxd), .txd_o(txd));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit tr [0:4095];

  // {divisor[47:32], mode[31:24], tick count[23:16], sample index[15:8], byte[7:0]}
  localparam logic [47:0] VT [6] = '{
    48'h0003_00_00_07_A5,
    48'h0002_02_00_01_3C,
    48'h0001_03_07_03_81,
    48'h0000_03_FF_7F_5A,
    48'h0004_01_00_07_FF,
    48'h0002_03_0B_05_00
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); addr = 3'd0; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic setup(input int dv, input int md, input int sc, input int sp);
    wr_reg(3'd3, 8'h83);
    wr_reg(3'd0, dv[7:0]);
    wr_reg(3'd1, dv[15:8]);
    wr_reg(3'd3, 8'h03);
    wr_reg(3'd2, md[7:0]);
    wr_reg(3'd4, sc[7:0]);
    wr_reg(3'd6, sp[7:0]);
  endtask

  // Sends a byte, records the line, and decodes it from the expected bit time
  task automatic xfer(input logic [7:0] b, input int tpb, input int dv,
                      output logic [7:0] got, output int span);
    int s, e, c, k, ix;
    @(negedge clk); addr = 3'd0; wdata = b; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 3'd5;
    s = -1; e = -1; c = 0;
    while (e < 0 && c < 4000) begin
      #1;
      tr[c] = txd;
      if (s < 0 && !txd) s = c;
      if (s >= 0 && rdata[6]) e = c;
      c++;
      @(negedge clk);
    end
    span = e - s;
    k = span - (10 * tpb - 1) * dv;
    got = 8'h00;
    for (int d = 0; d < 8; d++) begin
      ix = s + k + ((d + 1) * tpb - 1) * dv + (tpb * dv) / 2;
      if (ix >= 0 && ix < 4096) got[d] = tr[ix];
    end
  endtask

  initial begin
    logic [7:0] v, got;
    int span, dv, tpb, md;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = 3'd0; wdata = 8'h00;
    loop = 1'b0; rxd_drv = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd_reg(3'd5, v); chk(v == 8'h60, "R6 reset status", v, 8'h60);
    rd_reg(3'd3, v); chk(v == 8'h00, "R9 reset line control", v, 8'h00);
    rd_reg(3'd2, v); chk(v == 8'h00, "R2 reset mode", v, 8'h00);
    rd_reg(3'd4, v); chk(v == 8'h0F, "R2 reset tick count", v, 8'h0F);
    rd_reg(3'd6, v); chk(v == 8'h07, "R4 reset sample index", v, 8'h07);
    #1 chk(txd == 1'b1, "R5 idle line high", txd, 1);

    // Divisor access through the shared addresses
    wr_reg(3'd3, 8'h83);
    rd_reg(3'd3, v); chk(v == 8'h83, "R9 line control readback", v, 8'h83);
    rd_reg(3'd0, v); chk(v == 8'h01, "R1 reset divisor low", v, 8'h01);
    wr_reg(3'd0, 8'h34); wr_reg(3'd1, 8'h12);
    rd_reg(3'd0, v); chk(v == 8'h34, "R1 divisor low readback", v, 8'h34);
    rd_reg(3'd1, v); chk(v == 8'h12, "R1 divisor high readback", v, 8'h12);
    wr_reg(3'd3, 8'h03);
    wr_reg(3'd1, 8'h77);
    rd_reg(3'd1, v); chk(v == 8'h00, "R1 high byte hidden", v, 8'h00);
    rd_reg(3'd0, v); chk(v == 8'h00, "R8 data address shows rx byte", v, 8'h00);
    wr_reg(3'd3, 8'h83);
    rd_reg(3'd1, v); chk(v == 8'h12, "R1 hidden write ignored", v, 8'h12);
    wr_reg(3'd3, 8'h03);

    // Vector table: frame length, bit order and loopback reception
    loop = 1'b1;
    foreach (VT[i]) begin
      dv  = int'(VT[i][47:32]);
      md  = int'(VT[i][31:24]);
      tpb = (md == 2) ? 4 : (md == 3) ? int'(VT[i][23:16]) + 1 : 16;
      setup(dv, md, int'(VT[i][23:16]), int'(VT[i][15:8]));
      if (dv == 0) dv = 1;
      xfer(VT[i][7:0], tpb, dv, got, span);
      chk(span >= (10 * tpb - 1) * dv + 1 && span <= 10 * tpb * dv,
          "R2 R3 R5 frame length", span, 10 * tpb * dv);
      chk(got == VT[i][7:0], "R5 transmitted byte", got, VT[i][7:0]);
      rd_reg(3'd5, v); chk(v == 8'h61, "R6 status after frame", v, 8'h61);
      pop(v); chk(v == VT[i][7:0], "R8 loopback byte", v, VT[i][7:0]);
      rd_reg(3'd5, v); chk(v[0] == 1'b0, "R8 ready cleared by read", v[0], 0);
    end

    // R6: status during a frame, write while busy ignored
    setup(2, 2, 0, 1);
    wr_reg(3'd0, 8'h11);
    rd_reg(3'd5, v); chk(v == 8'h00, "R6 busy status", v, 8'h00);
    wr_reg(3'd0, 8'hEE);
    for (int n = 0; n < 200; n++) rd_reg(3'd5, v);
    chk(v == 8'h61, "R6 idle after one frame", v, 8'h61);
    begin
      bit quiet = 1'b1;
      for (int n = 0; n < 120; n++) begin @(negedge clk); if (!txd) quiet = 1'b0; end
      chk(quiet, "R6 busy write sent nothing", quiet, 1);
    end
    pop(v); chk(v == 8'h11, "R6 only first byte sent", v, 8'h11);

    // Sample index position and false start, driven directly
    loop = 1'b0;
    setup(4, 0, 0, 2);
    @(negedge clk); rxd_drv = 1'b0; repeat (40) @(negedge clk); rxd_drv = 1'b1;
    repeat (800) @(negedge clk);
    rd_reg(3'd5, v); chk(v[0] == 1'b1, "R4 early sample accepts short start", v[0], 1);
    pop(v); chk(v == 8'hFF, "R4 byte from short start", v, 8'hFF);

    wr_reg(3'd6, 8'd12);
    @(negedge clk); rxd_drv = 1'b0; repeat (40) @(negedge clk); rxd_drv = 1'b1;
    repeat (800) @(negedge clk);
    rd_reg(3'd5, v); chk(v[0] == 1'b0, "R7 late sample drops short start", v[0], 0);

    wr_reg(3'd6, 8'd200);
    @(negedge clk); rxd_drv = 1'b0; repeat (100) @(negedge clk); rxd_drv = 1'b1;
    repeat (800) @(negedge clk);
    rd_reg(3'd5, v); chk(v[0] == 1'b1, "R4 clamped index still samples", v[0], 1);
    pop(v); chk(v == 8'hFF, "R4 byte after clamped sample", v, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule